// File: doc/BRIEF.md
# Framebuffer Host Register Interface

This block gives a CPU word-wide access to a 4-bit-per-pixel video memory and to a 16-entry colour palette through six consecutive bus registers. Video memory is reached indirectly. The CPU loads one of two address pointers, then moves whole 32-bit pixel words through a single data register. The read pointer and the write pointer are separate. Each one advances by one after every data access that uses it, so block copies and fills need no further pointer writes.

The palette is also reached indirectly. The CPU selects a slot, and a later write to the palette data register emits one write pulse toward the palette store, carrying that slot and a 12-bit colour. A read-only status register reports a fixed mode code and the live vertical-blank flag. Every bus read returns its data one cycle after the read strobe. The memory array, the palette storage and the video timing are outside this block.

Top module: `fb_host_regs`

## Requirements
- R1: The registers sit at word addresses BASE+0 to BASE+5 (BASE defaults to 0x900) in this order: read pointer, write pointer, pixel data, palette slot select, palette colour data, status. A read of any other address returns 0, and a write to any other address changes nothing.
- R2: A bus read of the pixel data register returns the memory word at the read pointer on bus_rdata_o in the following cycle. The read pointer then holds its old value plus one.
- R3: A bus write of the pixel data register stores bus_wdata_i at the write pointer. The write pointer then holds its old value plus one.
- R4: The two pointers are independent. Each one loads from bus_wdata_i[13:0] when written and reads back zero-extended. Each one wraps from 16383 to 0.
- R5: A write to the slot select register keeps bits 3:0 and ignores the upper bits. Writes to the palette data register leave the slot unchanged. One cycle after a palette data write, pal_we_o pulses for one cycle with pal_idx_o set to the slot and pal_rgb_o set to bits 11:0 (red 11:8, green 7:4, blue 3:0).
- R6: Reads of the slot select register and the palette data register return 0.
- R7: A status read returns 1 in bits 31:28, vblank_i (as sampled at the read strobe) in bit 0, and 0 in every other bit. Writes to the status register have no effect.
- R8: A pixel data read asserts mem_re_o in the same cycle as the bus strobe, with mem_addr_o set to the read pointer. mem_re_o and mem_we_o are never high together.
- R9: After reset both pointers read 0, the palette slot is 0 and pal_we_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Bus word address |
| bus_we_i | input | 1 | Bus write strobe |
| bus_re_i | input | 1 | Bus read strobe |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, valid one cycle after bus_re_i |
| vblank_i | input | 1 | Vertical-blank flag from the video timing |
| mem_addr_o | output | 14 | Video memory word address |
| mem_re_o | output | 1 | Video memory read strobe |
| mem_we_o | output | 1 | Video memory write strobe |
| mem_wdata_o | output | 32 | Video memory write data |
| mem_rdata_i | input | 32 | Video memory read data, one cycle after mem_re_o |
| pal_we_o | output | 1 | Palette write pulse |
| pal_idx_o | output | 4 | Palette slot for the write |
| pal_rgb_o | output | 12 | Palette colour for the write |

## Verification
Two functions can fall in the same cycle. One is the return of read data for a pixel read issued in the previous cycle. The other is a new pixel write already driving the shared memory port. The bench provokes this with a back-to-back read-modify-write: the write strobe is applied in the cycle right after the read strobe. It then checks two things. The value returned must be the old word. A later read must see the modified word at the same address, with each pointer advanced only once.

// File: rtl/fb_regs_pkg.sv
package fb_regs_pkg;
  typedef enum logic [2:0] {
    SEL_RPTR  = 3'd0,
    SEL_WPTR  = 3'd1,
    SEL_PIX   = 3'd2,
    SEL_SLOT  = 3'd3,
    SEL_COLOR = 3'd4,
    SEL_STAT  = 3'd5,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 6;
  localparam logic [3:0] MODE_CODE = 4'd1;
endpackage

// File: rtl/fb_addr_latch.sv
module fb_addr_latch #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= load_val_i;
    else if (inc_i)   q <= q + W'(1);
  end

  assign q_o = q;
endmodule

// File: rtl/fb_pal_port.sv
module fb_pal_port #(
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned RGB_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_we_i,
  input  logic             color_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             pal_we_o,
  output logic [IDX_W-1:0] pal_idx_o,
  output logic [RGB_W-1:0] pal_rgb_o
);
  logic [IDX_W-1:0] slot_q;
  logic             we_q;
  logic [IDX_W-1:0] idx_q;
  logic [RGB_W-1:0] rgb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      we_q   <= 1'b0;
      idx_q  <= '0;
      rgb_q  <= '0;
    end else begin
      if (slot_we_i) slot_q <= wdata_i[IDX_W-1:0];
      we_q <= color_we_i;
      if (color_we_i) begin
        idx_q <= slot_q;
        rgb_q <= wdata_i[RGB_W-1:0];
      end
    end
  end

  assign pal_we_o  = we_q;
  assign pal_idx_o = idx_q;
  assign pal_rgb_o = rgb_q;

  assert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we_o && !$past(color_we_i) |-> 1'b0);
endmodule

// File: rtl/fb_host_regs.sv
module fb_host_regs
  import fb_regs_pkg::*;
#(
  parameter int unsigned    BUS_AW = 16,
  parameter logic [15:0]    BASE   = 16'h0900,
  parameter int unsigned    DW     = 32,
  parameter int unsigned    MEM_AW = 14,
  parameter int unsigned    IDX_W  = 4,
  parameter int unsigned    RGB_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              vblank_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              pal_we_o,
  output logic [IDX_W-1:0]  pal_idx_o,
  output logic [RGB_W-1:0]  pal_rgb_o
);
  localparam logic [BUS_AW-1:0] BASE_A = BUS_AW'(BASE);
  localparam int unsigned       PAD_W  = DW - MEM_AW;
  localparam int unsigned       MID_W  = DW - 5;

  reg_sel_e          sel;
  logic [BUS_AW-1:0] offs;
  logic              pix_rd, pix_wr;
  logic [MEM_AW-1:0] ptr_q [2];
  reg_sel_e          rsel_q;
  logic [DW-1:0]     rdata_q, rdata_d;

  // register decode
  always_comb begin
    offs = bus_addr_i - BASE_A;
    if (bus_addr_i >= BASE_A && offs < BUS_AW'(NUM_REGS)) sel = reg_sel_e'(offs[2:0]);
    else                                                 sel = SEL_NONE;
  end

  assign pix_rd = bus_re_i && (sel == SEL_PIX);
  assign pix_wr = bus_we_i && (sel == SEL_PIX);

  // index 0: read pointer, index 1: write pointer
  for (genvar g = 0; g < 2; g++) begin : gen_ptr
    fb_addr_latch #(.W(MEM_AW)) u_ptr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (bus_we_i && (sel == ((g == 0) ? SEL_RPTR : SEL_WPTR))),
      .load_val_i (bus_wdata_i[MEM_AW-1:0]),
      .inc_i      ((g == 0) ? pix_rd : pix_wr),
      .q_o        (ptr_q[g])
    );
  end

  assign mem_re_o    = pix_rd;
  assign mem_we_o    = pix_wr;
  assign mem_addr_o  = pix_wr ? ptr_q[1] : ptr_q[0];
  assign mem_wdata_o = bus_wdata_i;

  fb_pal_port #(.DW(DW), .IDX_W(IDX_W), .RGB_W(RGB_W)) u_pal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_we_i  (bus_we_i && (sel == SEL_SLOT)),
    .color_we_i (bus_we_i && (sel == SEL_COLOR)),
    .wdata_i    (bus_wdata_i),
    .pal_we_o   (pal_we_o),
    .pal_idx_o  (pal_idx_o),
    .pal_rgb_o  (pal_rgb_o)
  );

  // read path: registers captured at the strobe, pixel data passed from memory
  always_comb begin
    unique case (sel)
      SEL_RPTR: rdata_d = {{PAD_W{1'b0}}, ptr_q[0]};
      SEL_WPTR: rdata_d = {{PAD_W{1'b0}}, ptr_q[1]};
      SEL_STAT: rdata_d = {MODE_CODE, {MID_W{1'b0}}, vblank_i};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_q  <= SEL_NONE;
      rdata_q <= '0;
    end else begin
      rsel_q  <= bus_re_i ? sel : SEL_NONE;
      rdata_q <= bus_re_i ? rdata_d : '0;
    end
  end

  assign bus_rdata_o = (rsel_q == SEL_PIX) ? mem_rdata_i : rdata_q;

  assert_rd_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_rd |=> ptr_q[0] == $past(ptr_q[0]) + MEM_AW'(1));
  assert_wr_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_wr |=> ptr_q[1] == $past(ptr_q[1]) + MEM_AW'(1));
  assert_mem_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  assert_pal_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && sel == SEL_COLOR) |=> pal_we_o && pal_rgb_o == $past(bus_wdata_i[RGB_W-1:0]));
  assert_stat_ro_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && sel == SEL_STAT) |=> !pal_we_o && $stable(ptr_q[0]) && $stable(ptr_q[1]));
  assert_wo_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && (sel == SEL_SLOT || sel == SEL_COLOR)) |=> bus_rdata_o == '0);
endmodule

// File: tb/tb_fb_host_regs.sv
module tb_fb_host_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        vblank = 1'b0;
  logic [13:0] mem_addr;
  logic        mem_re, mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        pal_we;
  logic [3:0]  pal_idx;
  logic [11:0] pal_rgb;

  int tests = 0, fails = 0;
  logic [31:0] mem [256];
  logic [31:0] exp_mem [256];

  localparam logic [15:0] A_RP = 16'h0900, A_WP = 16'h0901, A_PIX = 16'h0902,
                          A_SLOT = 16'h0903, A_COL = 16'h0904, A_STAT = 16'h0905;

  always #4 clk = ~clk;

  fb_host_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_re_i(bus_re), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .vblank_i(vblank), .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .pal_we_o(pal_we),
    .pal_idx_o(pal_idx), .pal_rgb_o(pal_rgb)
  );

  // single-cycle memory model, 256 words aliased on the low address bits
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  function automatic logic [31:0] pat(input int i);
    return 32'h9E3779B9 * i + 32'h13572468;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, a0, b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset state
    chk("R9 pal_we", {31'b0, pal_we}, 32'h0);
    rd(A_RP, v);   chk("R9 read ptr", v, 32'h0);
    rd(A_WP, v);   chk("R9 write ptr", v, 32'h0);
    rd(A_STAT, v); chk("R7 status", v, 32'h1000_0000);

    // R3 write sweep, R2 read sweep
    wr(A_WP, 32'h0);
    for (int i = 0; i < 64; i++) begin
      wr(A_PIX, pat(i));
      exp_mem[i] = pat(i);
    end
    rd(A_WP, v); chk("R3 write ptr advanced", v, 32'd64);
    wr(A_RP, 32'h0);
    for (int i = 0; i < 64; i++) begin
      rd(A_PIX, v); chk("R2 pixel read", v, exp_mem[i]);
    end
    rd(A_RP, v); chk("R2 read ptr advanced", v, 32'd64);

    // R4 independence and load truncation
    wr(A_RP, 32'hFFFF_000A);
    wr(A_WP, 32'd200);
    rd(A_PIX, v); chk("R4 read uses own ptr", v, exp_mem[10]);
    rd(A_WP, v);  chk("R4 write ptr untouched", v, 32'd200);
    rd(A_RP, v);  chk("R4 read ptr loaded 14b", v, 32'd11);

    // R4 wrap
    a0 = 32'hCAFE_0001; b0 = 32'hBEEF_0002;
    wr(A_WP, 32'd16383);
    wr(A_PIX, a0); wr(A_PIX, b0);
    exp_mem[255] = a0; exp_mem[0] = b0;
    rd(A_WP, v); chk("R4 write ptr wrap", v, 32'd1);
    wr(A_RP, 32'd16383);
    rd(A_PIX, v); chk("R4 read at 16383", v, a0);
    rd(A_PIX, v); chk("R4 read after wrap", v, b0);
    rd(A_RP, v);  chk("R4 read ptr wrap", v, 32'd1);

    // R8 memory strobe in the bus cycle
    wr(A_RP, 32'd20);
    @(negedge clk);
    bus_addr = A_PIX; bus_re = 1'b1;
    #1;
    chk("R8 mem_re", {31'b0, mem_re}, 32'h1);
    chk("R8 mem_we low", {31'b0, mem_we}, 32'h0);
    chk("R8 mem_addr", {18'b0, mem_addr}, 32'd20);
    @(negedge clk);
    bus_re = 1'b0;
    chk("R2 read of word 20", bus_rdata, exp_mem[20]);

    // back-to-back read-modify-write on word 7
    wr(A_RP, 32'd7); wr(A_WP, 32'd7);
    @(negedge clk);
    bus_addr = A_PIX; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
    bus_we = 1'b1; bus_wdata = v ^ 32'h0000_FFFF;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R2 rmw old word", v, exp_mem[7]);
    exp_mem[7] = exp_mem[7] ^ 32'h0000_FFFF;
    rd(A_RP, v); chk("R2 rmw read ptr", v, 32'd8);
    rd(A_WP, v); chk("R3 rmw write ptr", v, 32'd8);
    wr(A_RP, 32'd7);
    rd(A_PIX, v); chk("R3 rmw new word", v, exp_mem[7]);

    // R5 palette sweep with upper select bits set
    for (int s = 0; s < 16; s++) begin
      wr(A_SLOT, 32'hABCD_EF00 | 32'(s));
      wr(A_COL, 32'hFFFF_F000 | 32'((s * 273) ^ 12'h5A3));
      chk("R5 pal_we", {31'b0, pal_we}, 32'h1);
      chk("R5 pal_idx", {28'b0, pal_idx}, 32'(s));
      chk("R5 pal_rgb", {20'b0, pal_rgb}, 32'(((s * 273) ^ 12'h5A3) & 12'hFFF));
    end
    @(negedge clk);
    chk("R5 single pulse", {31'b0, pal_we}, 32'h0);
    wr(A_SLOT, 32'd9);
    wr(A_COL, 32'h123);
    wr(A_COL, 32'h456);
    chk("R5 no auto-increment", {28'b0, pal_idx}, 32'd9);
    chk("R5 second colour", {20'b0, pal_rgb}, 32'h456);

    // R6 write-only registers read zero
    rd(A_SLOT, v); chk("R6 slot reads 0", v, 32'h0);
    rd(A_COL, v);  chk("R6 colour reads 0", v, 32'h0);

    // R7 status read-only and vblank
    wr(A_RP, 32'd33); wr(A_WP, 32'd44);
    wr(A_STAT, 32'hFFFF_FFFF);
    chk("R7 write no palette pulse", {31'b0, pal_we}, 32'h0);
    rd(A_STAT, v); chk("R7 status after write", v, 32'h1000_0000);
    rd(A_RP, v);   chk("R7 read ptr kept", v, 32'd33);
    rd(A_WP, v);   chk("R7 write ptr kept", v, 32'd44);
    vblank = 1'b1;
    rd(A_STAT, v); chk("R7 vblank set", v, 32'h1000_0001);
    vblank = 1'b0;

    // R1 unmapped addresses
    rd(16'h0906, v); chk("R1 above map reads 0", v, 32'h0);
    rd(16'h08FF, v); chk("R1 below map reads 0", v, 32'h0);
    wr(16'h0906, 32'd5); wr(16'h08FF, 32'd5);
    rd(A_RP, v); chk("R1 read ptr unchanged", v, 32'd33);
    rd(A_WP, v); chk("R1 write ptr unchanged", v, 32'd44);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule